// File: doc/BRIEF.md
# Erasable Byte-Wide PROM Model

This block is a cycle-based, synthesizable model of a byte-wide ultraviolet-erasable PROM. It is meant to stand in for such a memory inside a larger simulation or emulation build. In normal operation a host gives it an address, an active-low chip select and an active-low output gate, and reads bytes back. The model applies a configurable access latency to those reads. The tri-state data bus is split into two signals: `out_en` shows when the bus is driven, and `out_data` carries the value. While `out_en` is low, `out_data` reads zero.

A separate programming-voltage flag switches the block into programming operation. In that mode three control levels pick one of four actions:

- burn: add bits to a byte
- check: read a byte back, which also serves as the blank test
- hold off: neither write nor drive
- capture: latch the two upper address bits that share pins with two middle ones

Programming can only move a bit from the erased value 0 to 1. A bulk-erase request walks the whole array back to zero, one byte per cycle, and pulses a completion flag at the end.

Storage depth is a parameter (`MEM_AW` address bits, default 12), so the array stays small. Address bits above `MEM_AW` alias onto the stored bytes. All control pins are plain levels sampled on the rising clock edge. The block has no data stream with back-pressure: reads are paced only by the access latency, and the host can see that pacing on `out_valid`.

Top module: `uvprom_core`

## Requirements
- R1: In normal operation the stored byte is selected by `addr[MEM_AW-1:0]`. Addresses that differ only in bits at or above `MEM_AW` return the same byte.
- R2: With `hv_on`=0, `ce_n`=0 and `oe_n`=0, `out_en` is 1 after the next edge. `out_valid` is 1 and `out_data` equals the addressed byte only after both of these hold: `ce_n` has been low with the same `addr` for `ACC_CYC` consecutive sampled edges, and `oe_n` has been low for `OE_CYC` consecutive sampled edges. Before that, `out_valid` is 0 and `out_data` is 0. An address change restarts the `ACC_CYC` count at 1.
- R3: With `hv_on`=0, `ce_n`=0 and `oe_n`=1, `out_en` is 0 after the next edge.
- R4: With `hv_on`=0 and `ce_n`=1, `out_en` is 0 and `pwr_down` is 1 after the next edge, whatever `oe_n` is.
- R5: Burn is selected by `hv_on`=1, `burn_n`=0, `hi_cap`=0, `chk_n`=1. At every edge in this mode the byte at the programming address becomes its old value OR `din`, and `out_en` stays 0.
- R6: Check is selected by `hv_on`=1, `burn_n`=1, `hi_cap`=0, `chk_n`=0. One edge later `out_en` and `out_valid` are 1 and `out_data` is the byte at the programming address. A location that has not been burned since the last erase reads 0.
- R7: Hold-off is selected by `hv_on`=1 and `hi_cap`=0 with `burn_n`=`chk_n`. In hold-off `out_en` is 0 and no byte changes.
- R8: With `hv_on`=1 and `hi_cap`=1, each edge stores `addr[8]` as programming-address bit 11 and `addr[9]` as programming-address bit 10, and `out_en` is 0. The programming address is `addr` with bits 11 and 10 replaced by those held bits.
- R9: While `hv_on`=1, `ce_n` and `oe_n` have no effect. While `hv_on`=0, `burn_n`, `hi_cap`, `chk_n` and `din` have no effect.
- R10: `erase_go`=1 while idle starts an erase. `erase_busy` is then 1 for exactly 2**`MEM_AW` cycles, at the end of which every byte is 0. `erase_done` is 1 for the single cycle that follows. During `erase_busy`, `out_en` is 0, burns are blocked, and further `erase_go` pulses are ignored.
- R11: During reset `out_en`, `out_valid`, `out_data`, `pwr_down`, `erase_busy` and `erase_done` are 0, and both held address bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Byte address; bits 8 and 9 double as shared pins during capture |
| ce_n | input | 1 | Chip select, active low (normal operation) |
| oe_n | input | 1 | Output gate, active low (normal operation) |
| hv_on | input | 1 | Programming voltage present; selects programming operation |
| burn_n | input | 1 | Burn control level, low to write |
| hi_cap | input | 1 | Upper-address capture level |
| chk_n | input | 1 | Check control level, low to read back |
| din | input | DATA_W | Byte to OR into the array during burn |
| erase_go | input | 1 | Bulk-erase request |
| out_data | output | DATA_W | Read data, zero while not valid |
| out_en | output | 1 | Data bus driven (low models high impedance) |
| out_valid | output | 1 | Read data meets its access latency |
| pwr_down | output | 1 | Standby indicator |
| erase_busy | output | 1 | Erase in progress |
| erase_done | output | 1 | One-cycle pulse after an erase |

## Verification
Reads are tried in three ways:
- A fresh address with both enables falling together, which separates the access latency from the output-gate latency.
- An address change while the chip stays selected, which shows that the access count restarts.
- A gate-only re-enable on a settled address, which shows only the shorter gate latency applies.

Programming is tried in several ways:
- Two successive burns whose patterns overlap, which tells an OR from a plain overwrite.
- A hold-off and a burn attempt made with the programming voltage absent, which show no write leaks through.
- Two different captured upper-bit pairs, which show the shared pins land in bits 11 and 10 and not in 8 and 9.

A second erase that is re-requested mid-way shows that the length of an erase is fixed.

// File: rtl/prom_pkg.sv
package prom_pkg;

  typedef enum logic [2:0] {
    MD_READ    = 3'd0,
    MD_ODIS    = 3'd1,
    MD_PDOWN   = 3'd2,
    MD_BURN    = 3'd3,
    MD_CHECK   = 3'd4,
    MD_HOLDOFF = 3'd5,
    MD_CAPTURE = 3'd6
  } prom_mode_e;

  // Positions of the two upper bits carried on shared pins.
  localparam int SHARED_PIN_X = 8;
  localparam int SHARED_PIN_Y = 9;
  localparam int HELD_POS_X   = 11;
  localparam int HELD_POS_Y   = 10;

endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
  import prom_pkg::*;
(
  input  logic       hv_on,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       burn_n,
  input  logic       hi_cap,
  input  logic       chk_n,
  output prom_mode_e mode
);

  always_comb begin
    if (!hv_on) begin
      if (ce_n)      mode = MD_PDOWN;
      else if (oe_n) mode = MD_ODIS;
      else           mode = MD_READ;
    end else if (hi_cap) begin
      mode = MD_CAPTURE;
    end else begin
      unique case ({burn_n, chk_n})
        2'b01:   mode = MD_BURN;
        2'b10:   mode = MD_CHECK;
        default: mode = MD_HOLDOFF;
      endcase
    end
  end

endmodule

// File: rtl/prom_addr_latch.sv
module prom_addr_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic pin_x,
  input  logic pin_y,
  output logic held_x,
  output logic held_y
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_x <= 1'b0;
      held_y <= 1'b0;
    end else if (capture) begin
      held_x <= pin_x;
      held_y <= pin_y;
    end
  end

endmodule

// File: rtl/prom_read_timer.sv
module prom_read_timer #(
  parameter int ADDR_W  = 16,
  parameter int ACC_CYC = 6,
  parameter int OE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam int ACW = $clog2(ACC_CYC + 1);
  localparam int OCW = $clog2(OE_CYC + 1);
  localparam logic [ACW-1:0] ACC_LIM = ACW'(ACC_CYC);
  localparam logic [OCW-1:0] OE_LIM  = OCW'(OE_CYC);

  logic [ADDR_W-1:0] last_addr;
  logic [ACW-1:0]    acc_run, acc_nxt;
  logic [OCW-1:0]    oe_run, oe_nxt;

  always_comb begin
    if (ce_n)                   acc_nxt = '0;
    else if (addr != last_addr) acc_nxt = ACW'(1);
    else if (acc_run < ACC_LIM) acc_nxt = acc_run + ACW'(1);
    else                        acc_nxt = acc_run;

    if (oe_n)                   oe_nxt = '0;
    else if (oe_run < OE_LIM)   oe_nxt = oe_run + OCW'(1);
    else                        oe_nxt = oe_run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_addr <= '0;
      acc_run   <= '0;
      oe_run    <= '0;
    end else begin
      last_addr <= addr;
      acc_run   <= acc_nxt;
      oe_run    <= oe_nxt;
    end
  end

  assign ready = (acc_nxt >= ACC_LIM) && (oe_nxt >= OE_LIM);

endmodule

// File: rtl/prom_array.sv
module prom_array #(
  parameter int MEM_AW = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              burn_we,
  input  logic [DATA_W-1:0] burn_bits,
  input  logic              erase_go,
  output logic              erase_busy,
  output logic              erase_done
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [MEM_AW-1:0] wipe_ptr;
  logic              wipe_last;

  assign rd_data   = cells[idx];
  assign wipe_last = &wipe_ptr;

  // Storage: erase owns the port while busy; a burn can only add ones.
  always_ff @(posedge clk) begin
    if (erase_busy)   cells[wipe_ptr] <= '0;
    else if (burn_we) cells[idx]      <= rd_data | burn_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_busy <= 1'b0;
      erase_done <= 1'b0;
      wipe_ptr   <= '0;
    end else if (erase_busy) begin
      wipe_ptr   <= wipe_ptr + MEM_AW'(1);
      erase_busy <= !wipe_last;
      erase_done <= wipe_last;
    end else begin
      erase_done <= 1'b0;
      wipe_ptr   <= '0;
      erase_busy <= erase_go;
    end
  end

endmodule

// File: rtl/uvprom_core.sv
module uvprom_core
  import prom_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int MEM_AW  = 12,
  parameter int ACC_CYC = 6,
  parameter int OE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              hv_on,
  input  logic              burn_n,
  input  logic              hi_cap,
  input  logic              chk_n,
  input  logic [DATA_W-1:0] din,
  input  logic              erase_go,
  output logic [DATA_W-1:0] out_data,
  output logic              out_en,
  output logic              out_valid,
  output logic              pwr_down,
  output logic              erase_busy,
  output logic              erase_done
);

  localparam int LOW_BITS = HELD_POS_Y;

  prom_mode_e        mode;
  logic              held_x, held_y;
  logic              ready;
  logic [MEM_AW-1:0] norm_idx, prog_idx, arr_idx;
  logic [DATA_W-1:0] arr_data;

  prom_mode_dec u_dec (
    .hv_on  (hv_on),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .burn_n (burn_n),
    .hi_cap (hi_cap),
    .chk_n  (chk_n),
    .mode   (mode)
  );

  prom_addr_latch u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (mode == MD_CAPTURE),
    .pin_x   (addr[SHARED_PIN_X]),
    .pin_y   (addr[SHARED_PIN_Y]),
    .held_x  (held_x),
    .held_y  (held_y)
  );

  prom_read_timer #(
    .ADDR_W  (ADDR_W),
    .ACC_CYC (ACC_CYC),
    .OE_CYC  (OE_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .addr  (addr),
    .ready (ready)
  );

  assign norm_idx = addr[MEM_AW-1:0];

  generate
    if (MEM_AW > HELD_POS_X + 1) begin : g_wide
      assign prog_idx = {addr[MEM_AW-1:HELD_POS_X+1], held_x, held_y,
                         addr[LOW_BITS-1:0]};
    end else begin : g_narrow
      assign prog_idx = {held_x, held_y, addr[LOW_BITS-1:0]};
    end
  endgenerate

  assign arr_idx = (mode == MD_CHECK || mode == MD_BURN) ? prog_idx : norm_idx;

  prom_array #(
    .MEM_AW (MEM_AW),
    .DATA_W (DATA_W)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (arr_idx),
    .rd_data    (arr_data),
    .burn_we    (mode == MD_BURN),
    .burn_bits  (din),
    .erase_go   (erase_go),
    .erase_busy (erase_busy),
    .erase_done (erase_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_en    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      pwr_down  <= 1'b0;
    end else begin
      pwr_down <= (mode == MD_PDOWN);
      if (erase_busy) begin
        out_en    <= 1'b0;
        out_valid <= 1'b0;
        out_data  <= '0;
      end else begin
        unique case (mode)
          MD_READ: begin
            out_en    <= 1'b1;
            out_valid <= ready;
            out_data  <= ready ? arr_data : '0;
          end
          MD_CHECK: begin
            out_en    <= 1'b1;
            out_valid <= 1'b1;
            out_data  <= arr_data;
          end
          default: begin
            out_en    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/uvprom_core_chk.sv
module uvprom_core_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic hv_on,
  input logic burn_n,
  input logic hi_cap,
  input logic chk_n,
  input logic out_en,
  input logic out_valid,
  input logic pwr_down,
  input logic erase_busy,
  input logic erase_done
);

  // R2: valid data only on a driven bus
  a_r2_valid_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_en);

  // R3: output gate released floats the bus next cycle
  a_r3_gate_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (!hv_on && !ce_n && oe_n) |=> !out_en);

  // R4: deselect gives standby and a floating bus
  a_r4_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (!hv_on && ce_n) |=> (pwr_down && !out_en));

  // R6: check mode drives valid data
  a_r6_check_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_on && !hi_cap && burn_n && !chk_n && !erase_busy) |=> (out_en && out_valid));

  // R7: hold-off never drives
  a_r7_holdoff_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_on && !hi_cap && (burn_n == chk_n)) |=> !out_en);

  // R8: capture never drives
  a_r8_capture_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_on && hi_cap) |=> !out_en);

  // R10: completion follows the busy phase and lasts one cycle
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_done) |-> ($past(erase_busy) && !erase_busy));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> !erase_done);

  a_r10_busy_blocks_bus: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |=> !out_en);

endmodule

bind uvprom_core uvprom_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .hv_on      (hv_on),
  .burn_n     (burn_n),
  .hi_cap     (hi_cap),
  .chk_n      (chk_n),
  .out_en     (out_en),
  .out_valid  (out_valid),
  .pwr_down   (pwr_down),
  .erase_busy (erase_busy),
  .erase_done (erase_done)
);

// File: tb/tb_uvprom_core.sv
`timescale 1ns/1ps
module tb_uvprom_core;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int MEM_AW  = 12;
  localparam int ACC_CYC = 6;
  localparam int OE_CYC  = 2;
  localparam int DEPTH   = 1 << MEM_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, hv_on = 1'b0;
  logic burn_n = 1'b1, hi_cap = 1'b0, chk_n = 1'b1;
  logic [DATA_W-1:0] din = '0;
  logic erase_go = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic out_en, out_valid, pwr_down, erase_busy, erase_done;

  always #5 clk = ~clk;

  uvprom_core #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW),
    .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .hv_on(hv_on), .burn_n(burn_n), .hi_cap(hi_cap), .chk_n(chk_n),
    .din(din), .erase_go(erase_go), .out_data(out_data), .out_en(out_en),
    .out_valid(out_valid), .pwr_down(pwr_down), .erase_busy(erase_busy),
    .erase_done(erase_done)
  );

  int    errors = 0;
  int    checks = 0;
  bit    finished = 0;
  string cur_req = "R11";

  // ---------------- behavioural reference ----------------
  logic [7:0] ref_mem [DEPTH];
  int  m_run, m_orun, m_ptr;
  int  m_last;
  bit  m_hx, m_hy, m_busy, m_done, m_en, m_valid, m_pd;
  int  m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_orun = 0; m_last = 0; m_hx = 0; m_hy = 0;
      m_busy = 0; m_done = 0; m_ptr = 0;
      m_en = 0; m_valid = 0; m_data = 0; m_pd = 0;
    end else begin
      int  na, pa;
      bit  is_burn, is_check, is_read;
      na = int'(addr) % DEPTH;
      pa = (int'(addr) & 'h3FF) + (m_hy ? 'h400 : 0) + (m_hx ? 'h800 : 0)
           + ((int'(addr) % DEPTH) & ~'hFFF);
      is_read  = !hv_on && !ce_n && !oe_n;
      is_burn  = hv_on && !hi_cap && !burn_n && chk_n;
      is_check = hv_on && !hi_cap && burn_n && !chk_n;
      if (ce_n) m_run = 0;
      else if (int'(addr) != m_last) m_run = 1;
      else if (m_run < ACC_CYC) m_run++;
      if (oe_n) m_orun = 0;
      else if (m_orun < OE_CYC) m_orun++;
      m_last = int'(addr);
      m_pd = !hv_on && ce_n;
      if (m_busy) begin
        m_en = 0; m_valid = 0; m_data = 0;
      end else if (is_read) begin
        m_en = 1; m_valid = (m_run >= ACC_CYC) && (m_orun >= OE_CYC);
        m_data = m_valid ? int'(ref_mem[na]) : 0;
      end else if (is_check) begin
        m_en = 1; m_valid = 1; m_data = int'(ref_mem[pa]);
      end else begin
        m_en = 0; m_valid = 0; m_data = 0;
      end
      if (m_busy) begin
        ref_mem[m_ptr] = 8'h00;
        m_done = (m_ptr == DEPTH - 1);
        m_busy = !m_done;
        m_ptr++;
      end else begin
        m_done = 0;
        m_ptr = 0;
        if (is_burn) ref_mem[pa] = ref_mem[pa] | din;
        m_busy = erase_go;
      end
      if (hv_on && hi_cap) begin
        m_hx = addr[8];
        m_hy = addr[9];
      end
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(cur_req, int'(out_en), int'(m_en), "out_en vs model");
      chk(cur_req, int'(out_valid), int'(m_valid), "out_valid vs model");
      chk(cur_req, int'(out_data), m_data, "out_data vs model");
      chk(cur_req, int'(pwr_down), int'(m_pd), "pwr_down vs model");
      chk("R10", int'(erase_busy), int'(m_busy), "erase_busy vs model");
      chk("R10", int'(erase_done), int'(m_done), "erase_done vs model");
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic normal(int a, bit c, bit o);
    hv_on = 0; burn_n = 1; hi_cap = 0; chk_n = 1;
    addr = ADDR_W'(a); ce_n = c; oe_n = o;
  endtask

  task automatic prog(int a, bit b, bit h, bit v, int d);
    hv_on = 1; addr = ADDR_W'(a); burn_n = b; hi_cap = h; chk_n = v;
    din = DATA_W'(d);
  endtask

  task automatic run_erase(bit rerequest);
    int cnt;
    erase_go = 1; step(1); erase_go = 0;
    cnt = 0;
    while (erase_busy && cnt < DEPTH + 10) begin
      cnt++;
      if (rerequest && cnt == 20) erase_go = 1;
      step(1);
      erase_go = 0;
    end
    chk("R10", cnt, DEPTH, "busy cycle count");
    chk("R10", int'(erase_done), 1, "done after busy");
    step(1);
    chk("R10", int'(erase_done), 0, "done lasts one cycle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    step(2);
    cur_req = "R11";
    chk("R11", int'(out_en), 0, "reset out_en");
    chk("R11", int'(out_valid), 0, "reset out_valid");
    chk("R11", int'(out_data), 0, "reset out_data");
    chk("R11", int'(pwr_down), 0, "reset pwr_down");
    chk("R11", int'(erase_busy), 0, "reset erase_busy");
    rst_n = 1;
    step(1);

    cur_req = "R10";
    run_erase(0);

    // R8 capture: addr[8]=1 -> bit 11, addr[9]=0 -> bit 10
    cur_req = "R8";
    prog('h0100, 1, 1, 1, 0); step(1);
    chk("R8", int'(out_en), 0, "capture floats");
    // R5 burn at 0x935 (pins 9:8 = 01), two overlapping patterns
    cur_req = "R5";
    prog('h0135, 0, 0, 1, 'h05); step(1);
    chk("R5", int'(out_en), 0, "burn floats");
    prog('h0135, 0, 0, 1, 'h31); step(1);
    cur_req = "R6";
    prog('h0135, 1, 0, 0, 0); step(1);
    chk("R6", int'(out_data), 'h35, "check after OR burn");
    chk("R6", int'(out_valid), 1, "check valid");
    // R7 hold-off with data that would add bits
    cur_req = "R7";
    prog('h0135, 1, 0, 1, 'hC0); step(3);
    chk("R7", int'(out_en), 0, "hold-off floats");
    prog('h0135, 0, 0, 0, 'hC0); step(2);
    prog('h0135, 1, 0, 0, 0); step(1);
    chk("R7", int'(out_data), 'h35, "hold-off wrote nothing");
    // R9 chip select ignored during programming
    cur_req = "R9";
    ce_n = 1; oe_n = 1; step(1);
    chk("R9", int'(out_en), 1, "check drives with select high");

    // R2 normal read of 0x935
    cur_req = "R2";
    normal('h0935, 0, 0); step(ACC_CYC - 1);
    chk("R2", int'(out_valid), 0, "not valid before access count");
    chk("R2", int'(out_en), 1, "bus driven during access");
    step(1);
    chk("R2", int'(out_valid), 1, "valid at access count");
    chk("R2", int'(out_data), 'h35, "read data");
    // R1 alias above MEM_AW
    cur_req = "R1";
    normal('h1935, 0, 0); step(1);
    chk("R1", int'(out_valid), 0, "address change restarts count");
    step(ACC_CYC - 1);
    chk("R1", int'(out_data), 'h35, "aliased read");
    // R3 gate released
    cur_req = "R3";
    oe_n = 1; step(1);
    chk("R3", int'(out_en), 0, "gate high floats");
    cur_req = "R2";
    oe_n = 0; step(OE_CYC - 1);
    chk("R2", int'(out_valid), 0, "gate latency pending");
    step(1);
    chk("R2", int'(out_valid), 1, "gate latency met");
    // R4 deselect
    cur_req = "R4";
    ce_n = 1; step(1);
    chk("R4", int'(out_en), 0, "deselect floats");
    chk("R4", int'(pwr_down), 1, "standby");
    // R9 programming pins ignored without voltage
    cur_req = "R9";
    hv_on = 0; burn_n = 0; chk_n = 1; hi_cap = 0; din = 'hC0; ce_n = 1; step(3);
    hi_cap = 1; addr = 'h0000; step(2);
    prog('h0135, 1, 0, 0, 0); step(1);
    chk("R9", int'(out_data), 'h35, "no burn or capture without voltage");

    // second location with held bits 00 and blank check
    cur_req = "R8";
    prog('h0000, 1, 1, 1, 0); step(1);
    cur_req = "R5";
    prog('h00A5, 0, 0, 1, 'h81); step(1);
    cur_req = "R6";
    prog('h00A5, 1, 0, 0, 0); step(1);
    chk("R8", int'(out_data), 'h81, "held bits cleared");
    prog('h00A6, 1, 0, 0, 0); step(1);
    chk("R6", int'(out_data), 0, "blank check unburned");

    // R10 second erase with a re-request mid-way
    cur_req = "R10";
    prog('h00A5, 1, 0, 1, 0);
    run_erase(1);
    prog('h0100, 1, 1, 1, 0); step(1);
    prog('h0135, 1, 0, 0, 0); step(1);
    chk("R10", int'(out_data), 0, "erased byte reads zero");
    step(2);
    summary();
  end

endmodule